// File: doc/BRIEF.md
# Burst-Clocked Multichannel ADC Frame Reader

This block reads a complete multichannel sample frame from a serial ADC each time the converter signals that new data is ready. The ready signal is an active-low pulse. When the block sees its falling edge while idle, it opens a glitch-free gate on the system clock. The gated clock is driven out as the serial clock, at the full system clock rate, for exactly one pulse per frame bit. The default frame is eight channels of sixteen bits, which is 128 pulses.

The gate enable is a register clocked on the falling edge of the system clock, so the serial clock only starts or stops while the clock is low. A short or stretched pulse cannot appear. Serial data is sampled on each rising edge of the serial clock. The finished frame is split into per-channel words and held in output registers. A one-cycle strobe marks each new set of words. An active-low chip select frames the burst. The frame completes in 129 system clock cycles, well inside the 256-cycle spacing of the ready pulses.

Top module: `adc_burst_reader`

## Requirements
- R1: A falling edge on `drdy_n` while idle starts a burst. `cs_n` goes low half a clock cycle after the rising clock edge that sees the edge.
- R2: Every burst gives exactly NUM_CH*CH_W (default 128) serial clock pulses. Each pulse is one high phase of `clk`, so the serial clock runs at the full system clock rate.
- R3: `sclk` is low whenever `clk` is low. `sclk` is held low when idle. The gate opens and closes only during the low phase of `clk`, so every pulse has full width.
- R4: `sdata` is sampled on each rising `sclk` edge, MSB first and channel 0 first. The first bit received is bit 15 of channel 0. Channel k appears on `ch_data[16k+15:16k]`.
- R5: `frame_valid` is high for exactly one `clk` cycle per frame. `ch_data` changes only together with `frame_valid` and then holds until the next frame.
- R6: `frame_valid` is seen in the 129th clock cycle counted from the rising edge that detects the ready edge. This is the cycle right after the last bit and inside the 256-cycle ready spacing.
- R7: A falling edge on `drdy_n` during a burst, up to and including the last bit, is ignored. Holding `drdy_n` low starts only one burst.
- R8: `cs_n` is low for exactly the 128 cycles in which the gate is open. It rises half a cycle after the last serial clock rise, in the same cycle that `frame_valid` is first sampled high.
- R9: A synchronous active-high `rst` abandons any burst. It closes the gate, raises `cs_n`, clears `frame_valid` and zeroes `ch_data`.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the source of the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| drdy_n | input | 1 | Active-low data-ready pulse from the ADC |
| sdata | input | 1 | Serial data from the ADC |
| sclk | output | 1 | Gated serial clock burst |
| cs_n | output | 1 | Active-low chip select, low while the gate is open |
| ch_data | output | NUM_CH*CH_W (128) | Channel words; channel k at bits 16k+15:16k |
| frame_valid | output | 1 | One-cycle strobe when new channel words are loaded |

## Verification
The bench feeds several frame patterns:
- An all-zero and an all-one frame, which show that sampling works at all.
- Alternating bits, which expose an off-by-one in the bit timing.
- A walking-one pattern with a single set bit per channel, which tells a wrong channel order apart from a wrong bit order inside a word.
- Random frames from a fixed seed, which cover general data.

Extra ready edges in mid-burst and at the last bit, a ready line held low, and a reset in mid-burst show that the burst length and the latency stay fixed at 128 pulses and 129 cycles. Glitch monitors sample the serial clock in every low phase of the system clock and in every idle high phase.

// File: rtl/adc_burst_pkg.sv
package adc_burst_pkg;
  parameter int unsigned DEF_NUM_CH = 8;
  parameter int unsigned DEF_CH_W   = 16;

  function automatic int unsigned frame_bits(input int unsigned nch, input int unsigned cw);
    return nch * cw;
  endfunction
endpackage

// File: rtl/adc_drdy_trigger.sv
module adc_drdy_trigger (
  input  logic clk,
  input  logic rst,
  input  logic drdy_n,
  input  logic busy,
  output logic start
);
  logic drdy_q;

  always_ff @(posedge clk) begin
    if (rst) drdy_q <= 1'b1;
    else     drdy_q <= drdy_n;
  end

  // falling edge seen only while no burst is running
  assign start = drdy_q & ~drdy_n & ~busy;
endmodule

// File: rtl/adc_sclk_gate.sv
module adc_sclk_gate (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic gate_en,
  output logic sclk,
  output logic cs_n
);
  // enable and select move on the falling edge, so they change only while clk is low
  always_ff @(negedge clk) begin
    if (rst) begin
      gate_en <= 1'b0;
      cs_n    <= 1'b1;
    end else begin
      gate_en <= run;
      cs_n    <= ~run;
    end
  end

  assign sclk = clk & gate_en;
endmodule

// File: rtl/adc_frame_shifter.sv
module adc_frame_shifter #(
  parameter int unsigned FRAME_BITS = 128
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  gate_en,
  input  logic                  sdata,
  output logic                  run,
  output logic                  done,
  output logic [FRAME_BITS-1:0] frame_next
);
  localparam int unsigned CNT_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  logic [CNT_W-1:0]      bit_cnt;
  logic [FRAME_BITS-2:0] shreg;

  assign done       = gate_en & (bit_cnt == LAST);
  assign frame_next = {shreg, sdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      bit_cnt <= '0;
      shreg   <= '0;
    end else begin
      if (start) begin
        run     <= 1'b1;
        bit_cnt <= '0;
      end else if (done) begin
        run     <= 1'b0;
        bit_cnt <= '0;
      end else if (gate_en) begin
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (gate_en) shreg <= frame_next[FRAME_BITS-2:0];
    end
  end
endmodule

// File: rtl/adc_channel_regs.sv
module adc_channel_regs #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CH_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [NUM_CH*CH_W-1:0]   frame_in,
  output logic [NUM_CH*CH_W-1:0]   ch_data,
  output logic                     frame_valid
);
  localparam int unsigned FB = NUM_CH * CH_W;

  genvar k;
  generate
    for (k = 0; k < NUM_CH; k++) begin : g_ch
      // channel 0 arrives first, so it sits at the top of the received word
      always_ff @(posedge clk) begin
        if (rst)       ch_data[k*CH_W +: CH_W] <= '0;
        else if (load) ch_data[k*CH_W +: CH_W] <= frame_in[FB-1-k*CH_W -: CH_W];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) frame_valid <= 1'b0;
    else     frame_valid <= load;
  end
endmodule

// File: rtl/adc_burst_reader.sv
module adc_burst_reader
  import adc_burst_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  parameter int unsigned CH_W   = DEF_CH_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   drdy_n,
  input  logic                   sdata,
  output logic                   sclk,
  output logic                   cs_n,
  output logic [NUM_CH*CH_W-1:0] ch_data,
  output logic                   frame_valid
);
  localparam int unsigned FB = frame_bits(NUM_CH, CH_W);

  logic run, start, done, gate_en;
  logic [FB-1:0] frame_next;

  adc_drdy_trigger u_trig (
    .clk(clk), .rst(rst), .drdy_n(drdy_n), .busy(run), .start(start)
  );

  adc_sclk_gate u_gate (
    .clk(clk), .rst(rst), .run(run), .gate_en(gate_en), .sclk(sclk), .cs_n(cs_n)
  );

  adc_frame_shifter #(.FRAME_BITS(FB)) u_shift (
    .clk(clk), .rst(rst), .start(start), .gate_en(gate_en), .sdata(sdata),
    .run(run), .done(done), .frame_next(frame_next)
  );

  adc_channel_regs #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_regs (
    .clk(clk), .rst(rst), .load(done), .frame_in(frame_next),
    .ch_data(ch_data), .frame_valid(frame_valid)
  );
endmodule

// File: rtl/adc_burst_reader_chk.sv
module adc_burst_reader_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CH_W   = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   cs_n,
  input logic                   frame_valid,
  input logic [NUM_CH*CH_W-1:0] ch_data,
  input logic                   run,
  input logic                   gate_en
);
  p_valid_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> !frame_valid);

  p_valid_after_burst_r6: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> (cs_n && !$past(cs_n)));

  p_cs_end_gives_valid_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(cs_n)) |-> frame_valid);

  p_data_moves_with_valid_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(ch_data)) |-> frame_valid);

  p_gate_opens_after_run_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |=> gate_en);

  p_gate_closes_after_run_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(run) |=> !gate_en);
endmodule

bind adc_burst_reader adc_burst_reader_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .frame_valid(frame_valid),
  .ch_data(ch_data), .run(run), .gate_en(gate_en)
);

// File: tb/adc_burst_reader_bench.sv
module adc_burst_reader_bench;
  localparam int NCH = 8;
  localparam int CW  = 16;
  localparam int FB  = NCH * CW;

  logic clk = 1'b0, rst = 1'b1, drdy_n = 1'b1, sdata = 1'b0;
  wire  sclk, cs_n, frame_valid;
  wire  [FB-1:0] ch_data;

  adc_burst_reader u_adc_burst_reader (
    .clk(clk), .rst(rst), .drdy_n(drdy_n), .sdata(sdata),
    .sclk(sclk), .cs_n(cs_n), .ch_data(ch_data), .frame_valid(frame_valid)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0, pulses = 0, glitches = 0, idx = 0;
  logic [FB-1:0] cur_frame = '0;

  // ADC model: one bit presented per serial clock, updated in the clock low phase
  always @(posedge sclk) begin pulses++; idx++; end
  always @(negedge clk) sdata = (idx < FB) ? cur_frame[FB-1-idx] : 1'b0;

  // R3 monitors: sclk must be low in every clk low phase and in idle high phases
  always @(negedge clk) begin #5; if (sclk) glitches++; end
  always @(posedge clk) begin #5; if (cs_n && sclk) glitches++; end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [FB-1:0] act, input logic [FB-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [FB-1:0] exp_bus(input logic [FB-1:0] f);
    logic [FB-1:0] b;
    for (int k = 0; k < NCH; k++) b[k*CW +: CW] = f[FB-1-k*CW -: CW];
    return b;
  endfunction

  task automatic run_frame(input logic [FB-1:0] f, input int retrig_cyc, input bit hold_low);
    int valid_cyc = 0, valid_n = 0, cs_low = 0, p0, g0;
    cur_frame = f; idx = 0; p0 = pulses; g0 = glitches;
    @(negedge clk) drdy_n = 1'b0;
    for (int cyc = 1; cyc <= 256; cyc++) begin
      @(posedge clk); #5;
      if (cyc == 1) check(cs_n == 1'b1, "R1", "cs_n in detect cycle", FB'(cs_n), FB'(1));
      if (cyc == 2) check(cs_n == 1'b0, "R1", "cs_n after start", FB'(cs_n), FB'(0));
      if (!cs_n) cs_low++;
      if (frame_valid) begin valid_n++; if (valid_cyc == 0) valid_cyc = cyc; end
      if (cyc == 129) check(cs_n == 1'b0, "R8", "cs_n still low at valid sample", FB'(cs_n), FB'(0));
      if (cyc == 130) check(cs_n == 1'b1, "R8", "cs_n high after burst", FB'(cs_n), FB'(1));
      @(negedge clk);
      if (!hold_low) drdy_n = (cyc == retrig_cyc) ? 1'b0 : 1'b1;
    end
    drdy_n = 1'b1;
    check(pulses - p0 == FB, "R2", "sclk pulse count", FB'(pulses - p0), FB'(FB));
    check(glitches == g0, "R3", "sclk high outside gate", FB'(glitches - g0), FB'(0));
    check(valid_n == 1, "R5", "valid cycles", FB'(valid_n), FB'(1));
    check(valid_cyc == 129, "R6", "valid latency", FB'(valid_cyc), FB'(129));
    check(cs_low == FB, "R8", "cs_n low cycles", FB'(cs_low), FB'(FB));
    check(ch_data == exp_bus(f), "R4", "channel words", ch_data, exp_bus(f));
    if (retrig_cyc != 0 || hold_low)
      check(valid_n == 1 && pulses - p0 == FB, "R7", "extra ready edge ignored",
            FB'(pulses - p0), FB'(FB));
  endtask

  task automatic reset_mid_burst(input logic [FB-1:0] f);
    int p1;
    cur_frame = f; idx = 0;
    @(negedge clk) drdy_n = 1'b0;
    @(negedge clk) drdy_n = 1'b1;
    repeat (50) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #5;
    check(cs_n == 1'b1, "R9", "cs_n after reset", FB'(cs_n), FB'(1));
    check(frame_valid == 1'b0, "R9", "valid after reset", FB'(frame_valid), FB'(0));
    check(ch_data == '0, "R9", "channels after reset", ch_data, '0);
    check(sclk == 1'b0, "R9", "sclk in high phase after reset", FB'(sclk), FB'(0));
    p1 = pulses;
    repeat (200) @(posedge clk);
    #5;
    check(pulses == p1, "R9", "no pulses after reset", FB'(pulses - p1), FB'(0));
    check(ch_data == '0, "R9", "abandoned frame not loaded", ch_data, '0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [FB-1:0] f;
    void'($urandom(32'd20251));
    repeat (5) @(negedge clk);
    @(posedge clk); #5;
    check(cs_n == 1'b1, "R9", "cs_n in reset", FB'(cs_n), FB'(1));
    check(frame_valid == 1'b0, "R9", "valid in reset", FB'(frame_valid), FB'(0));
    check(ch_data == '0, "R9", "channels in reset", ch_data, '0);
    check(sclk == 1'b0, "R3", "sclk idle in reset", FB'(sclk), FB'(0));
    @(negedge clk) rst = 1'b0;
    repeat (3) @(negedge clk);

    run_frame('0, 0, 1'b0);
    run_frame('1, 0, 1'b0);
    for (int i = 0; i < FB / 2; i++) f[2*i +: 2] = 2'b10;
    run_frame(f, 0, 1'b0);
    // walking one: bit k of channel k (bit 15 of ch0 is the first bit received)
    f = '0;
    for (int k = 0; k < NCH; k++) f[FB-1-k*CW-(CW-1-k)] = 1'b1;
    run_frame(f, 0, 1'b0);
    run_frame({$urandom, $urandom, $urandom, $urandom}, 60, 1'b0);
    run_frame({$urandom, $urandom, $urandom, $urandom}, 128, 1'b0);
    run_frame({$urandom, $urandom, $urandom, $urandom}, 0, 1'b1);
    for (int n = 0; n < 12; n++)
      run_frame({$urandom, $urandom, $urandom, $urandom}, 0, 1'b0);
    reset_mid_burst({$urandom, $urandom, $urandom, $urandom});
    run_frame({$urandom, $urandom, $urandom, $urandom}, 0, 1'b0);
    finish_run();
  end
endmodule